// File: doc/BRIEF.md
# Serial-to-Byte Receive Converter

This block sits behind clock recovery and the frame aligner in a line receiver. It takes one received bit per bit strobe and collects the bits into parallel words. It presents the words on a byte-rate output clock that it derives itself by counting bit strobes. The word is 8 bits in full-width mode and 4 bits in half-width mode. A middle holding stage loads only when the frame aligner marks a byte boundary. The output stage copies the holding stage on the falling edge of the derived byte clock. As a result, the byte clock keeps a constant period across realignments. The cost is that the delay through the block depends on the phase between the boundary strobe and the byte clock.

Two source controls act on the serial input before it is assembled:
- **Signal detect.** Its polarity is set by a pin. While it is inactive, the received bit is replaced by zero, so the output drains the bytes already in flight and then settles at all zeros.
- **Diagnostic loopback.** This enable is active low. While it is asserted, the local transmit serial bit replaces the received bit.

The stream has no back-pressure.
- The bit strobe `bit_en` is the only valid qualifier, and there is no ready: every strobed bit is consumed in the cycle it is presented.
- The output side is paced only by the free-running byte clock and cannot be stalled.
- A new byte appears on `byte_out` on each falling byte-clock edge, and a downstream consumer must take it before the next falling edge.

Top module: `rxs_ser2byte`

## Requirements
- R1: While reset is asserted and right after it is released, `byte_out` is all zeros, `frame_pulse` is 0 and `byte_clk` is 1.
- R2: `byte_clk` changes only on cycles with `bit_en` high. Let P be the word length: 8 when `bus_wide`=1 and 4 when `bus_wide`=0. Number the strobes from 0, starting at the first strobe after reset. Just after strobe s, `byte_clk` is 0 exactly when (s mod P) lies between P/2-1 and P-2 inclusive, and is 1 otherwise. This holds whatever the phase of `frame_bnd`.
- R3: Bits are assembled MSB first: the first bit of a word received ends up in `byte_out[7]`.
- R4: A strobe with `frame_bnd` high closes a word. The holding stage then captures that strobe's bit together with the P-1 bits strobed before it.
- R5: `byte_out` changes only on the cycle in which `byte_clk` falls, and it then takes the holding-stage content. If a word closes on that same strobe, the output shows the word held before it, and the new word appears one byte-clock period later.
- R6: Let f be the strobe carrying the first bit of a word and s the strobe on which that word reaches `byte_out`. Then s-f lies between P and 2P-1 inclusive.
- R7: The `frame_flag` value that accompanies a closing strobe appears on `frame_pulse` with that word. It lasts exactly one byte-clock period, rising only on a falling byte-clock edge.
- R8: Signal detect is active when `sd_ttl` differs from `sd_pol`. With `sd_pol`=0, `sd_ttl` is active high; with `sd_pol`=1, it is active low.
- R9: While signal detect is inactive and loopback is off, received bits are taken as 0. Words closed in that state are output as all zeros, and once the in-flight words have drained `byte_out` stays all zeros.
- R10: While `lpbk_n`=0, `tx_bit` replaces `rx_bit` as the serial source whatever the signal-detect state.
- R11: In half-width mode (`bus_wide`=0), the four bits of a word appear on `byte_out[7:4]` with the first bit in bit 7, and `byte_out[3:0]` reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bit clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bit_en | input | 1 | Bit strobe; qualifies rx_bit, tx_bit and frame_bnd |
| rx_bit | input | 1 | Received serial bit |
| frame_bnd | input | 1 | Byte-boundary strobe from the frame aligner; marks the last bit of a word |
| frame_flag | input | 1 | Frame-start mark for the word closed by frame_bnd |
| sd_ttl | input | 1 | Signal-detect level |
| sd_pol | input | 1 | Signal-detect polarity select |
| bus_wide | input | 1 | 1: 8-bit words, 0: 4-bit words |
| lpbk_n | input | 1 | Diagnostic loopback enable, active low |
| tx_bit | input | 1 | Local transmit serial bit used in loopback |
| byte_out | output | 8 | Parallel output word |
| frame_pulse | output | 1 | Frame mark re-timed to the byte clock |
| byte_clk | output | 1 | Free-running byte-rate output clock |

## Verification
Loading the holding stage and transferring to the output can land on the same strobe, whenever a word closes on the strobe where the byte clock falls. The bench provokes this by placing four idle strobes after reset in full-width mode, so each closing strobe coincides with a falling edge. The scoreboard then expects every word one byte-clock period later than it would otherwise arrive, at the maximum delay of 2P-1 strobes. It also expects each frame mark to survive the clear that the same transfer would apply.

// File: rtl/rxs_pkg.sv
package rxs_pkg;
  typedef enum logic {
    BUS_HALF = 1'b0,
    BUS_FULL = 1'b1
  } bus_mode_e;
endpackage

// File: rtl/rxs_input_sel.sv
module rxs_input_sel (
  input  logic rx_bit,
  input  logic tx_bit,
  input  logic sd_ttl,
  input  logic sd_pol,
  input  logic lpbk_n,
  output logic src_bit
);
  logic sd_live;

  always_comb begin
    sd_live = sd_ttl ^ sd_pol;
    if (!lpbk_n)      src_bit = tx_bit;
    else if (sd_live) src_bit = rx_bit;
    else              src_bit = 1'b0;
  end
endmodule

// File: rtl/rxs_byte_clk.sv
module rxs_byte_clk
  import rxs_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bit_en,
  input  logic bus_wide,
  output logic xfer,
  output logic byte_clk
);
  localparam int unsigned CW = $clog2(W);
  localparam logic [CW:0] PER_FULL = (CW+1)'(W);
  localparam logic [CW:0] PER_HALF = (CW+1)'(W / 2);

  logic [CW-1:0] cnt;
  logic [CW:0]   per;
  logic [CW:0]   mid;
  logic [CW:0]   cnt_x;

  always_comb begin
    per   = (bus_mode_e'(bus_wide) == BUS_FULL) ? PER_FULL : PER_HALF;
    mid   = (per >> 1) - 1'b1;
    cnt_x = {1'b0, cnt};
    xfer  = bit_en && (cnt_x == mid);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt      <= '0;
      byte_clk <= 1'b1;
    end else if (bit_en) begin
      if (cnt_x >= per - 1'b1) begin
        cnt      <= '0;
        byte_clk <= 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
        if (cnt_x == mid) byte_clk <= 1'b0;
      end
    end
  end

  // R2
  clk_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(byte_clk));
endmodule

// File: rtl/rxs_deser.sv
module rxs_deser
  import rxs_pkg::*;
#(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_en,
  input  logic         src_bit,
  input  logic         frame_bnd,
  input  logic         frame_flag,
  input  logic         bus_wide,
  input  logic         xfer,
  output logic [W-1:0] hold_data,
  output logic         hold_fp
);
  localparam int unsigned HW = W / 2;

  logic [W-2:0] sr;
  logic [W-1:0] nxt;
  logic [W-1:0] word;

  always_comb begin
    nxt = {sr, src_bit};
    if (bus_mode_e'(bus_wide) == BUS_FULL) word = nxt;
    else                                   word = {nxt[HW-1:0], {HW{1'b0}}};
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sr        <= '0;
      hold_data <= '0;
      hold_fp   <= 1'b0;
    end else begin
      if (bit_en) sr <= nxt[W-2:0];
      if (bit_en && frame_bnd) begin
        hold_data <= word;
        hold_fp   <= frame_flag;
      end else if (xfer) begin
        hold_fp <= 1'b0;
      end
    end
  end

  // R3
  shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bit_en |=> $stable(sr));
endmodule

// File: rtl/rxs_out_reg.sv
module rxs_out_reg #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         xfer,
  input  logic [W-1:0] hold_data,
  input  logic         hold_fp,
  output logic [W-1:0] byte_out,
  output logic         frame_pulse
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      byte_out    <= '0;
      frame_pulse <= 1'b0;
    end else if (xfer) begin
      byte_out    <= hold_data;
      frame_pulse <= hold_fp;
    end
  end

  // R5
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !xfer |=> ($stable(byte_out) && $stable(frame_pulse)));
endmodule

// File: rtl/rxs_ser2byte.sv
module rxs_ser2byte #(
  parameter int unsigned W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         bit_en,
  input  logic         rx_bit,
  input  logic         frame_bnd,
  input  logic         frame_flag,
  input  logic         sd_ttl,
  input  logic         sd_pol,
  input  logic         bus_wide,
  input  logic         lpbk_n,
  input  logic         tx_bit,
  output logic [W-1:0] byte_out,
  output logic         frame_pulse,
  output logic         byte_clk
);
  logic         src_bit;
  logic         xfer;
  logic [W-1:0] hold_data;
  logic         hold_fp;

  rxs_input_sel u_sel (
    .rx_bit (rx_bit),
    .tx_bit (tx_bit),
    .sd_ttl (sd_ttl),
    .sd_pol (sd_pol),
    .lpbk_n (lpbk_n),
    .src_bit(src_bit)
  );

  rxs_byte_clk #(.W(W)) u_bclk (
    .clk     (clk),
    .rst_n   (rst_n),
    .bit_en  (bit_en),
    .bus_wide(bus_wide),
    .xfer    (xfer),
    .byte_clk(byte_clk)
  );

  rxs_deser #(.W(W)) u_deser (
    .clk       (clk),
    .rst_n     (rst_n),
    .bit_en    (bit_en),
    .src_bit   (src_bit),
    .frame_bnd (frame_bnd),
    .frame_flag(frame_flag),
    .bus_wide  (bus_wide),
    .xfer      (xfer),
    .hold_data (hold_data),
    .hold_fp   (hold_fp)
  );

  rxs_out_reg #(.W(W)) u_out (
    .clk        (clk),
    .rst_n      (rst_n),
    .xfer       (xfer),
    .hold_data  (hold_data),
    .hold_fp    (hold_fp),
    .byte_out   (byte_out),
    .frame_pulse(frame_pulse)
  );

  // R5
  out_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(byte_out) |-> $fell(byte_clk));

  // R7
  fp_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(frame_pulse) |-> $fell(byte_clk));
endmodule

// File: tb/test_rxs_ser2byte.sv
module test_rxs_ser2byte;
  localparam int W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic bit_en = 1'b0;
  logic rx_bit = 1'b0;
  logic frame_bnd = 1'b0;
  logic frame_flag = 1'b0;
  logic sd_ttl = 1'b1;
  logic sd_pol = 1'b0;
  logic bus_wide = 1'b1;
  logic lpbk_n = 1'b1;
  logic tx_bit = 1'b0;
  logic [W-1:0] byte_out;
  logic frame_pulse;
  logic byte_clk;

  always #5 clk = ~clk;

  rxs_ser2byte #(.W(W)) i_rxs_ser2byte (
    .clk(clk), .rst_n(rst_n), .bit_en(bit_en), .rx_bit(rx_bit),
    .frame_bnd(frame_bnd), .frame_flag(frame_flag), .sd_ttl(sd_ttl),
    .sd_pol(sd_pol), .bus_wide(bus_wide), .lpbk_n(lpbk_n), .tx_bit(tx_bit),
    .byte_out(byte_out), .frame_pulse(frame_pulse), .byte_clk(byte_clk)
  );

  typedef struct {
    logic [W-1:0] data;
    logic         fp;
    int           first;
    string        tag;
  } exp_t;

  exp_t sb[$];
  int n_chk = 0;
  int n_bad = 0;
  int drv_cnt = 0;
  int scount = 0;
  logic prev_bc = 1'b1;

  task automatic check(input bit ok, input string tag, input string what,
                       input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  function automatic int per();
    return bus_wide ? W : W / 2;
  endfunction

  task automatic do_reset(input logic wide);
    @(negedge clk);
    rst_n = 1'b0; bit_en = 1'b0; frame_bnd = 1'b0; frame_flag = 1'b0;
    bus_wide = wide; lpbk_n = 1'b1; sd_ttl = 1'b1; sd_pol = 1'b0;
    sb.delete();
    drv_cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic strobe(input logic r, input logic t, input logic bnd, input logic fl);
    @(negedge clk);
    bit_en = 1'b1; rx_bit = r; tx_bit = t; frame_bnd = bnd; frame_flag = fl;
    drv_cnt++;
  endtask

  task automatic gap(input int n);
    repeat (n) begin
      @(negedge clk);
      bit_en = 1'b0; frame_bnd = 1'b0; frame_flag = 1'b0;
    end
  endtask

  // driver: sends one word and pushes its expected image to the scoreboard
  task automatic send_word(input logic [W-1:0] rd, input logic [W-1:0] td,
                           input logic fl, input int gapn, input string tag);
    int p;
    int first;
    exp_t e;
    p = per();
    first = drv_cnt;
    for (int i = 0; i < p; i++) begin
      if (gapn > 0 && i > 0) gap(gapn);
      strobe(rd[W-1-i], td[W-1-i], (i == p-1), (i == p-1) ? fl : 1'b0);
    end
    if (!lpbk_n)              e.data = td;     // R10
    else if (sd_ttl ^ sd_pol) e.data = rd;     // R8
    else                      e.data = '0;     // R9
    if (!bus_wide) e.data[W/2-1:0] = '0;       // R11
    e.fp = fl; e.first = first; e.tag = tag;
    @(posedge clk); #3;
    sb.push_back(e);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) strobe(1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic drain(input string tag);
    idle(2 * per() + 2);
    @(posedge clk); #3;
    check(sb.size() == 0, tag, "words left undelivered", sb.size(), 0);
  endtask

  // monitor: byte clock shape and scoreboard compare at each falling edge
  initial begin
    int p;
    int m;
    logic exp_bc;
    exp_t e;
    forever begin
      @(posedge clk); #2;
      if (!rst_n) begin
        scount = 0;
        prev_bc = 1'b1;
      end else begin
        if (bit_en) begin
          p = per();
          m = scount % p;
          exp_bc = !(m >= p/2 - 1 && m <= p - 2);
          // R2
          check(byte_clk === exp_bc, "R2", "byte clock after strobe",
                int'(byte_clk), int'(exp_bc));
          if (prev_bc && !byte_clk && sb.size() > 0) begin
            e = sb.pop_front();
            check(byte_out === e.data, e.tag, "output word",
                  int'(byte_out), int'(e.data));
            // R7
            check(frame_pulse === e.fp, "R7", "frame pulse",
                  int'(frame_pulse), int'(e.fp));
            // R6
            check((scount - e.first >= p) && (scount - e.first <= 2*p - 1),
                  "R6", "latency in strobes", scount - e.first, 2*p - 1);
          end
          scount++;
        end else begin
          // R2: no strobe, no change
          check(byte_clk === prev_bc, "R2", "byte clock held without strobe",
                int'(byte_clk), int'(prev_bc));
        end
        prev_bc = byte_clk;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1: reset state
    do_reset(1'b1);
    check(byte_out === '0, "R1", "output word after reset", int'(byte_out), 0);
    check(frame_pulse === 1'b0, "R1", "frame pulse after reset", int'(frame_pulse), 0);
    check(byte_clk === 1'b1, "R1", "byte clock after reset", int'(byte_clk), 1);

    // R3 R4: MSB-first assembly, closing strobe loads the holding stage
    send_word(8'h80, 8'h00, 1'b1, 0, "R3 R4");
    send_word(8'hA5, 8'h00, 1'b0, 0, "R3 R4");
    send_word(8'h3C, 8'h00, 1'b0, 0, "R3 R4");
    send_word(8'h01, 8'h00, 1'b1, 0, "R3 R4");
    drain("R4");

    // R5: closing strobe lands on the transfer strobe (four idle strobes)
    do_reset(1'b1);
    idle(4);
    send_word(8'hC3, 8'h00, 1'b1, 0, "R5");
    send_word(8'h5A, 8'h00, 1'b0, 0, "R5");
    send_word(8'hFF, 8'h00, 1'b1, 0, "R5");
    drain("R5");

    // R6: shortest and an intermediate phase
    do_reset(1'b1);
    idle(3);
    send_word(8'h96, 8'h00, 1'b0, 0, "R6");
    send_word(8'h69, 8'h00, 1'b1, 0, "R6");
    drain("R6");
    do_reset(1'b1);
    idle(5);
    send_word(8'h12, 8'h00, 1'b1, 0, "R6");
    send_word(8'hED, 8'h00, 1'b0, 0, "R6");
    drain("R6");

    // R2: gaps between strobes keep the byte clock frozen
    do_reset(1'b1);
    idle(2);
    send_word(8'hB7, 8'h00, 1'b1, 2, "R2");
    send_word(8'h4E, 8'h00, 1'b0, 3, "R2");
    drain("R2");

    // R8: polarity of signal detect
    do_reset(1'b1);
    sd_ttl = 1'b0; sd_pol = 1'b1;
    send_word(8'hD2, 8'h00, 1'b0, 0, "R8");
    sd_ttl = 1'b1; sd_pol = 1'b1;
    send_word(8'h7E, 8'h00, 1'b0, 0, "R8");
    sd_ttl = 1'b0; sd_pol = 1'b0;
    send_word(8'hE7, 8'h00, 1'b0, 0, "R8");
    sd_ttl = 1'b1; sd_pol = 1'b0;
    send_word(8'h24, 8'h00, 1'b1, 0, "R8");
    drain("R8");

    // R9: loss of signal flushes to zero
    do_reset(1'b1);
    idle(1);
    send_word(8'hAB, 8'h00, 1'b0, 0, "R9");
    sd_ttl = 1'b0;
    send_word(8'hFF, 8'h00, 1'b1, 0, "R9");
    send_word(8'h99, 8'h00, 1'b0, 0, "R9");
    drain("R9");
    check(byte_out === '0, "R9", "settled output word", int'(byte_out), 0);

    // R10: loopback source wins, even with signal detect inactive
    do_reset(1'b1);
    lpbk_n = 1'b0;
    send_word(8'h0F, 8'hC6, 1'b1, 0, "R10");
    sd_ttl = 1'b0;
    send_word(8'hF0, 8'h3B, 1'b0, 0, "R10");
    drain("R10");

    // R11: half-width words on the upper nibble
    do_reset(1'b0);
    send_word(8'hA0, 8'h00, 1'b1, 0, "R11");
    send_word(8'h5F, 8'h00, 1'b0, 0, "R11");
    idle(2);
    send_word(8'hCF, 8'h00, 1'b0, 0, "R11");
    send_word(8'h3F, 8'h00, 1'b1, 0, "R11");
    drain("R11");
    check(byte_out[W/2-1:0] === '0, "R11", "lower nibble", int'(byte_out), 0);

    gap(2);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule